// File: doc/BRIEF.md
# Masked burst write engine

This block is the write side of a device that holds a data array and a mask array, each indexed by a 14-bit location. A host drives a 9-bit command bus with a valid strobe and a 68-bit data bus. A write command takes two command cycles. The first selects single or burst mode and picks one of eight global mask registers. The second carries the device ID, the target and the location. The data cycles follow. Every array write is a read-modify-write, so only the bits enabled by the selected mask register change.

Bursts take their start location and beat count from a burst register, which the host programs beforehand through a register write. The block steps the burst address on every beat and drives an end-of-transfer pin with an output enable that brackets the last beat. Single writes to external memory appear as a one-cycle strobe carrying the upper address bits from the command bus.

The command side follows valid/ready rules. A command is taken only in a cycle where `cmd_valid` and `ready` are both high. Any command presented while `ready` is low is dropped and is not held, so the host must wait for `ready` before it starts a command. Data beats carry no handshake: they are positional, in the cycles that follow the second command cycle. The storage depth is 2^AW entries. The default AW is 8; AW = 14 gives the full 16K depth. A read-only lookup port shows the stored words to the compare logic next to the block.

Top module: `mbw_engine`

## Requirements
- R1: After reset, `ready` is 1 and `eot`, `eot_oe` and `sram_we` are 0. Both arrays read as all zeros. All eight mask registers are all ones. The burst register holds start 0 and count 0.
- R2: A command is accepted in a cycle with `cmd_valid`=1, `ready`=1 and `cmd[1:0]`=2'b01, and `ready` drops in the next cycle. The second cycle goes on only if `cmd_valid`=1, `cmd[1:0]`=2'b01 and `dq_in[25:21]` equals `dev_id`. If any of these fails, the block returns to ready in the following cycle and no storage changes.
- R3: In the second command cycle, `dq_in[20:19]` selects the target: 00 is the data array, 01 is the mask array, 10 is the register space and 11 is external memory. `dq_in[13:0]` is the location, and the arrays use its low AW bits.
- R4: A single write takes its data in the cycle right after the second command cycle. One idle cycle with `ready` low follows, and `ready` returns in the cycle after that.
- R5: An array write changes only the bits that are 1 in mask register `cmd[5:3]`, captured in the first command cycle. All other bits keep their value, and the lookup port shows the result from the next cycle on.
- R6: A single register write at location k in 0..7 replaces mask register k with the full 68-bit word, with no masking. Location 8 loads the burst register: the start from `dq_in[AW-1:0]` and the count from `dq_in[21:14]`.
- R7: With `cmd[2]`=1 in the first command cycle, a burst writes n beats to consecutive addresses from the burst start, one beat per cycle, where n is the count (a count of 0 means 1). Addresses wrap modulo 2^AW. Afterwards the burst start is left at the address after the last beat.
- R8: During a burst beat, `eot_oe` is 1 on every beat except the first, and also on the first beat when it is the only one. `eot` is 1 only on the last beat. In the cycle after the last beat, `eot_oe` is 1 and `eot` is 0. After that cycle `eot_oe` is 0.
- R9: A single write to external memory raises `sram_we` for exactly its data cycle. In that cycle `sram_addr` is {`cmd[8:6]` from the first command cycle, location} and `sram_wdata` equals `dq_in`.
- R10: Commands presented while `ready` is 0, including during burst beats and the closing cycle, are ignored.
- R11: A burst aimed at the register space or at external memory is aborted in the second command cycle, like any other failed check in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | Strapped device identity |
| cmd_valid | input | 1 | Command cycle valid |
| cmd | input | 9 | Command word: opcode, mode, mask index, upper memory address |
| ready | output | 1 | Engine idle and able to take a command |
| dq_in | input | 68 | Header in command cycles, write data in data cycles |
| eot | output | 1 | End-of-transfer level |
| eot_oe | output | 1 | Drive enable for the end-of-transfer pin |
| sram_we | output | 1 | External memory write strobe |
| sram_addr | output | 17 | External memory address {upper 3 bits, location} |
| sram_wdata | output | 68 | External memory write data |
| lkp_sel | input | 1 | Lookup bank: 0 data array, 1 mask array |
| lkp_addr | input | AW | Lookup address |
| lkp_data | output | 68 | Stored word at the lookup address |

## Verification
The bench runs several kinds of write against a behavioural model and scans both arrays after each one. Full-mask writes and writes under a striped mask tell a correct merge apart from a plain overwrite or an inverted mask. A one-beat burst straight after reset, a four-beat burst that crosses the top of the address space, and a following burst that must carry on from where the first one stopped separate correct stepping, wrap and address retention from off-by-one faults. A two-beat burst and a burst with count zero check the edge cases of the end-of-transfer pattern. Spoiled second cycles, an illegal burst target and commands issued while busy must leave storage untouched and bring `ready` back on time.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  // command bus layout (decoded by the sequencer, fixed by the protocol)
  localparam int CMD_W = 9;
  localparam logic [1:0] OP_WRITE = 2'b01;
  // header layout on the data bus during command cycles
  localparam int ID_LSB  = 21;
  localparam int TGT_LSB = 19;
  localparam int LOC_W   = 14;
  // burst register layout inside a register write word
  localparam int BLEN_LSB = 14;
  // mask register selection
  localparam int GIDX_W = 3;
  localparam int NGMR   = 1 << GIDX_W;
  localparam int SHI_W  = 3;

  typedef enum logic [1:0] {
    TGT_DATA = 2'b00,
    TGT_MASK = 2'b01,
    TGT_REG  = 2'b10,
    TGT_SRAM = 2'b11
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD2,
    ST_DATA,
    ST_BURST,
    ST_END
  } st_e;
endpackage

// File: rtl/mbw_cmd_fsm.sv
module mbw_cmd_fsm
  import mbw_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int BLEN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     dev_id,
  input  logic                cmd_valid,
  input  logic [CMD_W-1:0]    cmd,
  input  logic [ID_W-1:0]     hdr_id,
  input  logic [1:0]          hdr_tgt,
  input  logic [LOC_W-1:0]    hdr_loc,
  input  logic [BLEN_W-1:0]   blen,
  output logic                ready,
  output logic                eot,
  output logic                eot_oe,
  output logic                arr_we,
  output logic                reg_we,
  output logic                sram_we,
  output logic                burst_step,
  output tgt_e                tgt,
  output logic [LOC_W-1:0]    loc,
  output logic [GIDX_W-1:0]   gidx,
  output logic [SHI_W-1:0]    sram_hi
);
  st_e               st;
  logic              burst_q;
  logic              first_q;
  logic [BLEN_W-1:0] left_q;

  logic op_ok, id_ok, go, last;
  tgt_e tgt_in;

  assign op_ok  = cmd_valid && (cmd[1:0] == OP_WRITE);
  assign id_ok  = (hdr_id == dev_id);
  assign tgt_in = tgt_e'(hdr_tgt);
  // bursts are legal only toward the two arrays
  assign go     = op_ok && id_ok && !(burst_q && tgt_in[1]);
  assign last   = (left_q == BLEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      burst_q <= 1'b0;
      first_q <= 1'b0;
      left_q  <= '0;
      tgt     <= TGT_DATA;
      loc     <= '0;
      gidx    <= '0;
      sram_hi <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (op_ok) begin
            st      <= ST_CMD2;
            burst_q <= cmd[2];
            gidx    <= cmd[5:3];
            sram_hi <= cmd[8:6];
          end
        end
        ST_CMD2: begin
          tgt     <= tgt_in;
          loc     <= hdr_loc;
          left_q  <= (blen == '0) ? BLEN_W'(1) : blen;
          first_q <= 1'b1;
          if (go) st <= burst_q ? ST_BURST : ST_DATA;
          else    st <= ST_IDLE;
        end
        ST_DATA: st <= ST_END;
        ST_BURST: begin
          left_q  <= left_q - 1'b1;
          first_q <= 1'b0;
          if (last) st <= ST_END;
        end
        ST_END:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready      = (st == ST_IDLE);
    burst_step = (st == ST_BURST);
    arr_we     = ((st == ST_DATA) && !tgt[1]) || burst_step;
    reg_we     = (st == ST_DATA) && (tgt == TGT_REG);
    sram_we    = (st == ST_DATA) && (tgt == TGT_SRAM);
    eot        = burst_step && last;
    eot_oe     = (burst_step && (!first_q || last)) || ((st == ST_END) && burst_q);
  end
endmodule

// File: rtl/mbw_regs.sv
module mbw_regs
  import mbw_pkg::*;
#(
  parameter int DW     = 68,
  parameter int AW     = 8,
  parameter int BLEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [LOC_W-1:0]   reg_loc,
  input  logic [DW-1:0]      wdata,
  input  logic [GIDX_W-1:0]  gidx,
  input  logic               burst_step,
  output logic [DW-1:0]      gmask,
  output logic [AW-1:0]      bstart,
  output logic [BLEN_W-1:0]  blen
);
  logic [DW-1:0] gmr [NGMR];

  always_ff @(posedge clk) begin
    for (int g = 0; g < NGMR; g++) begin
      if (!rst_n) gmr[g] <= '1;
      else if (reg_we && reg_loc == LOC_W'(g)) gmr[g] <= wdata;
    end
  end

  assign gmask = gmr[gidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bstart <= '0;
      blen   <= '0;
    end else if (reg_we && reg_loc == LOC_W'(NGMR)) begin
      bstart <= wdata[AW-1:0];
      blen   <= wdata[BLEN_LSB +: BLEN_W];
    end else if (burst_step) begin
      bstart <= bstart + 1'b1;
    end
  end
endmodule

// File: rtl/mbw_array.sv
module mbw_array #(
  parameter int DW = 68,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask,
  input  logic          lkp_sel,
  input  logic [AW-1:0] lkp_addr,
  output logic [DW-1:0] lkp_data
);
  localparam int DEPTH = 1 << AW;
  localparam int NBANK = 2;

  logic [NBANK-1:0][DW-1:0] rd;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] old;
    assign old   = mem[waddr];
    assign rd[b] = mem[lkp_addr];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && sel == 1'(b)) begin
        mem[waddr] <= (old & ~mask) | (wdata & mask);
      end
    end
  end

  assign lkp_data = rd[lkp_sel];
endmodule

// File: rtl/mbw_engine.sv
module mbw_engine
  import mbw_pkg::*;
#(
  parameter int DW     = 68,
  parameter int AW     = 8,
  parameter int ID_W   = 5,
  parameter int BLEN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ID_W-1:0]        dev_id,
  input  logic                   cmd_valid,
  input  logic [CMD_W-1:0]       cmd,
  output logic                   ready,
  input  logic [DW-1:0]          dq_in,
  output logic                   eot,
  output logic                   eot_oe,
  output logic                   sram_we,
  output logic [SHI_W+LOC_W-1:0] sram_addr,
  output logic [DW-1:0]          sram_wdata,
  input  logic                   lkp_sel,
  input  logic [AW-1:0]          lkp_addr,
  output logic [DW-1:0]          lkp_data
);
  logic              arr_we, reg_we, burst_step;
  tgt_e              tgt;
  logic [LOC_W-1:0]  loc;
  logic [GIDX_W-1:0] gidx;
  logic [SHI_W-1:0]  sram_hi;
  logic [DW-1:0]     gmask;
  logic [AW-1:0]     bstart;
  logic [BLEN_W-1:0] blen;
  logic [AW-1:0]     waddr;

  mbw_cmd_fsm #(.ID_W(ID_W), .BLEN_W(BLEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
    .cmd_valid(cmd_valid), .cmd(cmd),
    .hdr_id(dq_in[ID_LSB +: ID_W]), .hdr_tgt(dq_in[TGT_LSB +: 2]),
    .hdr_loc(dq_in[LOC_W-1:0]), .blen(blen),
    .ready(ready), .eot(eot), .eot_oe(eot_oe),
    .arr_we(arr_we), .reg_we(reg_we), .sram_we(sram_we),
    .burst_step(burst_step), .tgt(tgt), .loc(loc),
    .gidx(gidx), .sram_hi(sram_hi)
  );

  mbw_regs #(.DW(DW), .AW(AW), .BLEN_W(BLEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_loc(loc),
    .wdata(dq_in), .gidx(gidx), .burst_step(burst_step),
    .gmask(gmask), .bstart(bstart), .blen(blen)
  );

  assign waddr = burst_step ? bstart : loc[AW-1:0];

  mbw_array #(.DW(DW), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .sel(tgt[0]),
    .waddr(waddr), .wdata(dq_in), .mask(gmask),
    .lkp_sel(lkp_sel), .lkp_addr(lkp_addr), .lkp_data(lkp_data)
  );

  assign sram_addr  = {sram_hi, loc};
  assign sram_wdata = dq_in;
endmodule

// File: rtl/mbw_engine_chk.sv
module mbw_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [8:0] cmd,
  input logic       ready,
  input logic       eot,
  input logic       eot_oe,
  input logic       sram_we
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && cmd[1:0] == 2'b01) |=> !ready); // R2
  AST_EOT_IS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> eot_oe); // R8
  AST_EOT_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> (eot_oe && !eot)); // R8
  AST_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eot_oe |-> !ready); // R10
  AST_SRAM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !sram_we); // R9
  AST_IDLE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !ready); // R4
endmodule

bind mbw_engine mbw_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
  .ready(ready), .eot(eot), .eot_oe(eot_oe), .sram_we(sram_we)
);

// File: tb/mbw_engine_tb.sv
module mbw_engine_tb;
  localparam int DEPTH = 256;
  localparam logic [4:0] MY_ID = 5'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd = '0;
  logic [67:0] dq_in = '0;
  logic        lkp_sel = 1'b0;
  logic [7:0]  lkp_addr = '0;
  logic        ready, eot, eot_oe, sram_we;
  logic [16:0] sram_addr;
  logic [67:0] sram_wdata, lkp_data;

  always #10 clk = ~clk;

  mbw_engine u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(MY_ID), .cmd_valid(cmd_valid), .cmd(cmd),
    .ready(ready), .dq_in(dq_in), .eot(eot), .eot_oe(eot_oe),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .lkp_sel(lkp_sel), .lkp_addr(lkp_addr), .lkp_data(lkp_data)
  );

  // reference model state
  logic [67:0] md [DEPTH];
  logic [67:0] mm [DEPTH];
  logic [67:0] gm [8];
  int          bst, bln;
  logic [16:0] exp_saddr;
  logic        pl_sel;
  int          pl_addr;
  int          ncmp = 0, nbad = 0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [67:0] pat(input int s, input int j);
    logic [31:0] w;
    w = s * 32'h9E3779B1 + j * 32'h85EBCA6B + 32'h1234567;
    return {s[3:0] ^ 4'hA, w, ~w};
  endfunction

  function automatic logic [67:0] hdr(input logic [1:0] t, input int loc, input logic [4:0] id);
    return {42'h0, id, t, 5'h0, loc[13:0]};
  endfunction

  // one clock: drive after the edge, compare at the falling edge
  task automatic cyc(input logic v, input logic [8:0] c, input logic [67:0] d,
                     input logic er, input logic ee, input logic eoe, input logic ewe,
                     input string rtag);
    logic [67:0] ex;
    @(posedge clk); #1;
    cmd_valid = v; cmd = c; dq_in = d;
    lkp_sel = pl_sel; lkp_addr = pl_addr[7:0];
    @(negedge clk);
    chk(ready === er, rtag, "ready", 68'(ready), 68'(er));
    chk(eot === ee, "R8", "eot", 68'(eot), 68'(ee));
    chk(eot_oe === eoe, "R8", "eot_oe", 68'(eot_oe), 68'(eoe));
    chk(sram_we === ewe, "R9", "sram_we", 68'(sram_we), 68'(ewe));
    if (ewe) begin
      chk(sram_addr === exp_saddr, "R9", "sram_addr", 68'(sram_addr), 68'(exp_saddr));
      chk(sram_wdata === d, "R9", "sram_wdata", sram_wdata, d);
    end
    ex = pl_sel ? mm[pl_addr] : md[pl_addr];
    chk(lkp_data === ex, "R5", "lookup word", lkp_data, ex);
  endtask

  task automatic mwrite(input logic sel, input int a, input logic [67:0] d, input int gi);
    if (sel) mm[a] = (mm[a] & ~gm[gi]) | (d & gm[gi]);
    else     md[a] = (md[a] & ~gm[gi]) | (d & gm[gi]);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 9'h0, 68'h0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic scan();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < DEPTH; a++) begin
        pl_sel = s[0]; pl_addr = a;
        cyc(1'b0, 9'h0, 68'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      end
  endtask

  task automatic single(input logic [1:0] t, input int loc, input int gi,
                        input logic [67:0] d, input logic [2:0] hi, input string tag);
    logic [67:0] h;
    h = hdr(t, loc, MY_ID);
    cyc(1'b1, {hi, gi[2:0], 1'b0, 2'b01}, h, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    cyc(1'b1, {3'b000, gi[2:0], 1'b0, 2'b01}, h, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    exp_saddr = {hi, loc[13:0]};
    cyc(1'b0, 9'h0, d, 1'b0, 1'b0, 1'b0, t == 2'b11, tag);
    if (t == 2'b00 || t == 2'b01) mwrite(t[0], loc % DEPTH, d, gi);
    else if (t == 2'b10) begin
      if (loc < 8) gm[loc] = d;
      else if (loc == 8) begin bst = int'(d[7:0]); bln = int'(d[21:14]); end
    end
    cyc(1'b0, 9'h0, 68'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    idle(1, "R4");
  endtask

  // burst; commands presented on every busy cycle must be dropped (R10)
  task automatic burst(input logic [1:0] t, input int gi, input int seed, input string tag);
    logic [67:0] h, d;
    int n;
    bit last;
    n = (bln == 0) ? 1 : bln;
    h = hdr(t, 0, MY_ID);
    cyc(1'b1, {3'b000, gi[2:0], 1'b1, 2'b01}, h, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    cyc(1'b1, {3'b000, gi[2:0], 1'b0, 2'b01}, h, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    for (int j = 0; j < n; j++) begin
      last = (j == n - 1);
      d = pat(seed, j);
      cyc(1'b1, 9'h001, d, 1'b0, last, (j >= 1) || last, 1'b0, "R10");
      mwrite(t[0], bst, d, gi);
      bst = (bst + 1) % DEPTH;
    end
    cyc(1'b1, 9'h001, hdr(2'b00, 3, MY_ID), 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    idle(1, "R7");
  endtask

  // kind: 0 wrong ID, 1 wrong opcode, 2 valid low, 3 burst to registers, 4 burst to memory
  task automatic spoil(input int kind, input string tag);
    logic [67:0] h;
    logic [8:0] c1, c2;
    logic v2;
    h = hdr(kind == 3 ? 2'b10 : (kind == 4 ? 2'b11 : 2'b00), kind == 3 ? 8 : 9, MY_ID);
    c1 = {3'b111, 3'd0, (kind >= 3), 2'b01};
    c2 = {3'b000, 3'd0, 1'b0, (kind == 1) ? 2'b11 : 2'b01};
    v2 = (kind != 2);
    if (kind == 0) h = hdr(2'b00, 9, MY_ID ^ 5'h01);
    cyc(1'b1, c1, h, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    cyc(v2, c2, h, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    cyc(1'b0, 9'h0, {46'h0, 8'd3, 14'd40}, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    idle(1, tag);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin md[a] = '0; mm[a] = '0; end
    for (int g = 0; g < 8; g++) gm[g] = '1;
    bst = 0; bln = 0; pl_sel = 1'b0; pl_addr = 0; exp_saddr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3, "R1");                                  // R1 reset state
    burst(2'b00, 3, 1, "R7");                       // R1/R7: reset register gives one beat at 0
    single(2'b00, 5, 0, pat(2, 0), 3'b000, "R3");
    single(2'b10, 2, 0, {17{4'h6}}, 3'b000, "R6");  // R6 mask register 2
    single(2'b00, 5, 2, '1, 3'b000, "R5");          // R5 merge under striped mask
    single(2'b01, 7, 2, pat(3, 1), 3'b000, "R3");
    single(2'b11, 16'h1234, 0, pat(4, 2), 3'b101, "R9");
    scan();
    single(2'b10, 8, 0, {46'h0, 8'd4, 14'd254}, 3'b000, "R6");
    burst(2'b00, 2, 5, "R7");                       // R7 wrap 254..1
    burst(2'b01, 0, 6, "R7");                       // R7 continues at 2
    single(2'b10, 8, 0, {46'h0, 8'd0, 14'd100}, 3'b000, "R6");
    burst(2'b01, 0, 7, "R7");                       // R7 count zero means one beat
    single(2'b10, 8, 0, {46'h0, 8'd2, 14'd10}, 3'b000, "R6");
    burst(2'b00, 2, 8, "R8");                       // R8 two-beat pattern
    scan();
    spoil(0, "R2");
    spoil(1, "R2");
    spoil(2, "R2");
    spoil(3, "R11");
    spoil(4, "R11");
    cyc(1'b1, 9'h002, hdr(2'b00, 4, MY_ID), 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    idle(2, "R2");                                  // R2 bad first opcode never accepted
    burst(2'b00, 0, 9, "R11");                      // register kept start 12, count 2
    scan();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end
endmodule